// File: doc/BRIEF.md
# Three-Bus Processor Datapath

This block is the register-transfer core of a small processor. Operands travel to the arithmetic unit over two source buses, A and B. The result returns over a single destination bus, C. The sources are a general register file with two read ports, the program counter and the memory data register. Every writable register loads only from bus C. Several registers may take the same bus C value at one clock edge. There are no staging registers around the arithmetic unit. A full source-to-destination transfer with an operation therefore completes in one clock cycle.

A sequencer outside this block supplies a flat control word every cycle. The word holds a source select for each source bus, the operation code, a write-enable mask for the register file, load and increment strobes for the program counter, a load strobe for the memory data register, a flag-update strobe, and memory read and write strobes. The memory side has a read-data input and a write-data output for the memory data register. The three buses, the flags and the program counter are brought out as ports, so the state can be observed.

Top module: `three_bus_datapath`

## Requirements
- R1: Bus C carries the result of the operation code applied to A (first operand) and B (second): 0 add, 1 subtract (A-B), 2 AND, 3 OR, 4 XOR, 5 pass A, 6 pass B, 7 drives zero; results wrap to the data width.
- R2: The flags output is {overflow, carry, zero} (bit 2, bit 1, bit 0). It loads at the clock edge only when flag_we is high and otherwise holds. Zero means a zero result. Carry is the carry-out for add and the borrow (A < B unsigned) for subtract, and 0 for other codes. Overflow is the signed overflow of add or subtract, and 0 otherwise.
- R3: Bus A shows register k for select values 0..N-1 (N registers) and the memory data register for select N+1. Every other select value, including N, gives zero.
- R4: Bus B shows register k for select values 0..N-1, the program counter for select N and the memory data register for select N+1. Every other select value gives zero.
- R5: At a clock edge, every register whose bit is set in the write mask takes the current bus C value, and several registers may load in the same edge; unselected registers keep their values.
- R6: A register that is read and written in the same cycle shows its old value on the source buses until after the edge.
- R7: The program counter drives its current value on bus B while it advances by one when pc_inc is high. pc_we loads it from bus C, and pc_we takes priority over pc_inc.
- R8: When mem_rd is high, the memory data register loads from mem_rdata. When mem_rd is low and mdr_we is high, it loads from bus C. mem_rd takes priority.
- R9: mem_wdata shows the memory data register while mem_wr is high and zero otherwise.
- R10: Reset (active-low, asynchronous) clears all general registers, the program counter, the memory data register and the flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | SELW (4) | Source select for bus A |
| sel_b | input | SELW (4) | Source select for bus B |
| alu_op | input | 3 | Operation code |
| rf_we | input | NREGS (8) | Register file write mask, bit k writes register k |
| pc_we | input | 1 | Load program counter from bus C |
| pc_inc | input | 1 | Advance program counter |
| mdr_we | input | 1 | Load memory data register from bus C |
| flag_we | input | 1 | Update flags |
| mem_rd | input | 1 | Load memory data register from mem_rdata |
| mem_wr | input | 1 | Present memory data register on mem_wdata |
| mem_rdata | input | W (16) | Data read from memory |
| mem_wdata | output | W (16) | Data to be written to memory |
| bus_a | output | W (16) | Bus A value |
| bus_b | output | W (16) | Bus B value |
| bus_c | output | W (16) | Bus C value |
| flags | output | 3 | Flag register {V, C, Z} |
| pc | output | W (16) | Program counter |

## Verification
Assertions in the register file and the top level check, on every cycle, the clock-edge state changes: each enabled register loads bus C and each other register holds. They also check that the program counter steps or loads, that a memory read lands in the memory data register, and that the flags hold when not enabled. The scenarios cover the rest. These are the operation codes and their flag values at the carry, borrow and signed-overflow boundaries, the source select decoding including the unused codes, read-during-write ordering, the conflicts between pc_we and pc_inc and between mem_rd and mdr_we, writes to several destinations in one cycle, and the reset values seen through the buses.

// File: rtl/three_bus_pkg.sv
package three_bus_pkg;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_XOR   = 3'd4,
        ALU_PASSA = 3'd5,
        ALU_PASSB = 3'd6,
        ALU_ZERO  = 3'd7
    } alu_op_e;

    localparam int FLG_Z = 0;
    localparam int FLG_C = 1;
    localparam int FLG_V = 2;
    localparam int FLG_W = 3;

endpackage

// File: rtl/tbd_regfile.sv
module tbd_regfile #(
    parameter int W     = 16,
    parameter int NREGS = 8,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREGS-1:0] we,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [W-1:0]     rdata_a,
    output logic [W-1:0]     rdata_b
);

    logic [W-1:0] regs_d [NREGS];
    logic [W-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = we[i] ? wdata : regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    // Read ports see the registered state, so a same-cycle write is not visible yet.
    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg_chk
        // R5
        rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we[g] |=> regs_q[g] == $past(wdata));
        // R5
        rf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !we[g] |=> $stable(regs_q[g]));
    end

endmodule

// File: rtl/tbd_alu.sv
module tbd_alu
    import three_bus_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [2:0]       op,
    output logic [W-1:0]     result,
    output logic [FLG_W-1:0] flg
);

    logic [W:0] wide;
    logic       carry;
    logic       ovf;

    always_comb begin
        wide  = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        unique case (alu_op_e'(op))
            ALU_ADD: begin
                wide  = {1'b0, opnd_a} + {1'b0, opnd_b};
                carry = wide[W];
                ovf   = (opnd_a[W-1] == opnd_b[W-1]) && (wide[W-1] != opnd_a[W-1]);
            end
            ALU_SUB: begin
                wide  = {1'b0, opnd_a} - {1'b0, opnd_b};
                carry = wide[W];
                ovf   = (opnd_a[W-1] != opnd_b[W-1]) && (wide[W-1] != opnd_a[W-1]);
            end
            ALU_AND:   wide = {1'b0, opnd_a & opnd_b};
            ALU_OR:    wide = {1'b0, opnd_a | opnd_b};
            ALU_XOR:   wide = {1'b0, opnd_a ^ opnd_b};
            ALU_PASSA: wide = {1'b0, opnd_a};
            ALU_PASSB: wide = {1'b0, opnd_b};
            default:   wide = '0;
        endcase
        result     = wide[W-1:0];
        flg        = '0;
        flg[FLG_Z] = (wide[W-1:0] == '0);
        flg[FLG_C] = carry;
        flg[FLG_V] = ovf;
    end

endmodule

// File: rtl/tbd_src_mux.sv
module tbd_src_mux #(
    parameter int W          = 16,
    parameter int NREGS      = 8,
    parameter bit PC_VISIBLE = 1'b1,
    localparam int SELW      = $clog2(NREGS + 2)
) (
    input  logic [SELW-1:0] sel,
    input  logic [W-1:0]    rf_data,
    input  logic [W-1:0]    pc_val,
    input  logic [W-1:0]    mdr_val,
    output logic [W-1:0]    bus
);

    localparam logic [SELW-1:0] SEL_PC  = SELW'(NREGS);
    localparam logic [SELW-1:0] SEL_MDR = SELW'(NREGS + 1);
    localparam logic [SELW-1:0] SEL_RF  = SELW'(NREGS);

    logic [W-1:0] pc_path;

    // The parameter picks whether the program counter is wired into this bus at all.
    if (PC_VISIBLE) begin : g_pc_on
        assign pc_path = pc_val;
    end else begin : g_pc_off
        assign pc_path = '0;
    end

    always_comb begin
        if (sel < SEL_RF)        bus = rf_data;
        else if (sel == SEL_PC)  bus = pc_path;
        else if (sel == SEL_MDR) bus = mdr_val;
        else                     bus = '0;
    end

endmodule

// File: rtl/three_bus_datapath.sv
module three_bus_datapath
    import three_bus_pkg::*;
#(
    parameter int W       = 16,
    parameter int NREGS   = 8,
    parameter int PC_STEP = 1,
    localparam int SELW   = $clog2(NREGS + 2),
    localparam int AW     = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SELW-1:0]  sel_a,
    input  logic [SELW-1:0]  sel_b,
    input  logic [2:0]       alu_op,
    input  logic [NREGS-1:0] rf_we,
    input  logic             pc_we,
    input  logic             pc_inc,
    input  logic             mdr_we,
    input  logic             flag_we,
    input  logic             mem_rd,
    input  logic             mem_wr,
    input  logic [W-1:0]     mem_rdata,
    output logic [W-1:0]     mem_wdata,
    output logic [W-1:0]     bus_a,
    output logic [W-1:0]     bus_b,
    output logic [W-1:0]     bus_c,
    output logic [2:0]       flags,
    output logic [W-1:0]     pc
);

    typedef struct packed {
        logic [W-1:0]     pc;
        logic [W-1:0]     mdr;
        logic [FLG_W-1:0] flg;
    } state_t;

    state_t           st_d, st_q;
    logic [W-1:0]     rf_a, rf_b;
    logic [FLG_W-1:0] alu_flg;

    tbd_regfile #(.W(W), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .wdata   (bus_c),
        .raddr_a (sel_a[AW-1:0]),
        .raddr_b (sel_b[AW-1:0]),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    tbd_src_mux #(.W(W), .NREGS(NREGS), .PC_VISIBLE(1'b0)) u_mux_a (
        .sel     (sel_a),
        .rf_data (rf_a),
        .pc_val  (st_q.pc),
        .mdr_val (st_q.mdr),
        .bus     (bus_a)
    );

    tbd_src_mux #(.W(W), .NREGS(NREGS), .PC_VISIBLE(1'b1)) u_mux_b (
        .sel     (sel_b),
        .rf_data (rf_b),
        .pc_val  (st_q.pc),
        .mdr_val (st_q.mdr),
        .bus     (bus_b)
    );

    tbd_alu #(.W(W)) u_alu (
        .opnd_a (bus_a),
        .opnd_b (bus_b),
        .op     (alu_op),
        .result (bus_c),
        .flg    (alu_flg)
    );

    always_comb begin
        st_d = st_q;
        if (pc_we)       st_d.pc = bus_c;
        else if (pc_inc) st_d.pc = st_q.pc + W'(PC_STEP);
        if (mem_rd)      st_d.mdr = mem_rdata;
        else if (mdr_we) st_d.mdr = bus_c;
        if (flag_we)     st_d.flg = alu_flg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc        = st_q.pc;
    assign flags     = st_q.flg;
    assign mem_wdata = mem_wr ? st_q.mdr : '0;

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !pc_we) |=> pc == $past(pc) + W'(PC_STEP));
    // R7
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> pc == $past(bus_c));
    // R8
    mdr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr -> mem_wdata == $past(mem_rdata)));
    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags));

endmodule

// File: tb/three_bus_datapath_tb.sv
module three_bus_datapath_tb_top;

    localparam int W     = 16;
    localparam int N     = 8;
    localparam int SELW  = 4;
    localparam int SPC   = N;
    localparam int SMDR  = N + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [SELW-1:0] sel_a = '0, sel_b = '0;
    logic [2:0]      alu_op = '0;
    logic [N-1:0]    rf_we = '0;
    logic            pc_we = 0, pc_inc = 0, mdr_we = 0, flag_we = 0, mem_rd = 0, mem_wr = 0;
    logic [W-1:0]    mem_rdata = '0;
    logic [W-1:0]    mem_wdata, bus_a, bus_b, bus_c, pc;
    logic [2:0]      flags;

    three_bus_datapath #(.W(W), .NREGS(N)) dut_i (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Scoreboard queues: which output, the expected value and the requirement tags.
    int           kind_q[$];
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    // Reference state, updated from the requirements.
    logic [W-1:0] m_regs [N];
    logic [W-1:0] m_pc, m_mdr;
    logic [2:0]   m_flg;

    function automatic logic [W-1:0] src_val(input int s, input bit is_b);
        if (s < N) return m_regs[s];
        if (s == SPC) return is_b ? m_pc : '0;
        if (s == SMDR) return m_mdr;
        return '0;
    endfunction

    task automatic push(input int k, input logic [W-1:0] e, input string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic step(input int sa, input int sb, input int op, input logic [N-1:0] we,
                        input bit pwe, input bit pinc, input bit mwe, input bit fwe,
                        input bit mrd, input bit mwr, input logic [W-1:0] rdata, input string tag);
        logic [W-1:0] a, b, c;
        logic [W:0]   wide;
        logic         cy, ov;
        @(negedge clk);
        sel_a = SELW'(sa); sel_b = SELW'(sb); alu_op = 3'(op); rf_we = we;
        pc_we = pwe; pc_inc = pinc; mdr_we = mwe; flag_we = fwe;
        mem_rd = mrd; mem_wr = mwr; mem_rdata = rdata;
        a = src_val(sa, 0);
        b = src_val(sb, 1);
        cy = 0; ov = 0;
        case (op)
            0: begin wide = {1'b0, a} + {1'b0, b}; cy = wide[W];
                     ov = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]); end
            1: begin wide = {1'b0, a} - {1'b0, b}; cy = (a < b);
                     ov = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]); end
            2: wide = {1'b0, a & b};
            3: wide = {1'b0, a | b};
            4: wide = {1'b0, a ^ b};
            5: wide = {1'b0, a};
            6: wide = {1'b0, b};
            default: wide = '0;
        endcase
        c = wide[W-1:0];
        push(0, a, {"R3 ", tag});
        push(1, b, {"R4 ", tag});
        push(2, c, {"R1 ", tag});
        push(3, W'(m_flg), {"R2 ", tag});
        push(4, m_pc, {"R7 ", tag});
        push(5, mwr ? m_mdr : '0, {"R9 ", tag});
        for (int i = 0; i < N; i++) if (we[i]) m_regs[i] = c;
        if (pwe) m_pc = c; else if (pinc) m_pc = m_pc + 1'b1;
        if (mrd) m_mdr = rdata; else if (mwe) m_mdr = c;
        if (fwe) m_flg = {ov, cy, (c == '0)};
    endtask

    // Shorthands.
    task automatic alu(input int sa, input int sb, input int op, input logic [N-1:0] we,
                       input bit fwe, input string tag);
        step(sa, sb, op, we, 0, 0, 0, fwe, 0, 0, '0, tag);
    endtask

    task automatic load_reg(input int r, input logic [W-1:0] v, input string tag);
        step(15, 15, 7, '0, 0, 0, 0, 0, 1, 0, v, tag);
        alu(SMDR, 15, 5, N'(1) << r, 0, tag);
    endtask

    function automatic logic [W-1:0] observed(input int k);
        case (k)
            0: return bus_a;
            1: return bus_b;
            2: return bus_c;
            3: return W'(flags);
            4: return pc;
            default: return mem_wdata;
        endcase
    endfunction

    // Monitor: compares everything queued for this cycle, well after the driver settles.
    always @(negedge clk) begin
        #2;
        while (kind_q.size() > 0) begin
            int           k;
            logic [W-1:0] e, o;
            string        t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            o = observed(k);
            checks++;
            if (o !== e) begin
                errors++;
                $display("FAIL %s out%0d actual %h expected %h", t, k, o, e);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_regs[i] = '0;
        m_pc = '0; m_mdr = '0; m_flg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset values seen through the buses
        for (int i = 0; i < N; i++) step(i, SPC, 0, '0, 0, 0, 0, 0, 0, 1, '0, "R10");
        alu(SMDR, SMDR, 3, '0, 0, "R10");

        // R8 memory read to MDR, R5 to registers
        load_reg(1, 16'h1234, "R8 R5");
        load_reg(2, 16'h00FF, "R8 R5");
        // R5 several destinations at once
        alu(1, 2, 4, 8'b0011_1000, 0, "R5 multi");
        alu(3, 4, 3, '0, 0, "R5 multi read");
        alu(5, 0, 5, '0, 0, "R5 multi read");

        // R1 every operation code, with flags
        for (int op = 0; op < 8; op++) begin
            alu(1, 2, op, 8'b0100_0000, 1, "R1 op sweep");
            alu(6, 2, 6, '0, 0, "R1 result read");
        end
        alu(2, 1, 1, '0, 1, "R2 borrow");
        load_reg(3, 16'h7FFF, "R2 setup");
        load_reg(4, 16'h0001, "R2 setup");
        alu(3, 4, 0, '0, 1, "R2 signed overflow add");
        load_reg(5, 16'hFFFF, "R2 setup");
        alu(5, 4, 0, '0, 1, "R2 carry zero");
        load_reg(6, 16'h8000, "R2 setup");
        alu(6, 4, 1, '0, 1, "R2 signed overflow sub");
        alu(4, 4, 1, '0, 1, "R2 equal sub");
        // R2 flags hold when not enabled
        alu(3, 4, 0, '0, 0, "R2 hold");
        alu(5, 4, 0, '0, 0, "R2 hold");

        // R6 read and write the same register
        alu(1, 1, 0, 8'b0000_0010, 0, "R6 same cycle");
        alu(1, 15, 5, '0, 0, "R6 after edge");

        // R7 PC advances while driving bus B
        step(0, SPC, 6, '0, 0, 1, 0, 0, 0, 0, '0, "R7 inc");
        step(0, SPC, 6, '0, 0, 1, 0, 0, 0, 0, '0, "R7 inc");
        step(0, SPC, 6, 8'b1000_0000, 0, 1, 0, 0, 0, 0, '0, "R7 inc");
        // R7 load beats increment
        step(2, 0, 5, '0, 1, 1, 0, 0, 0, 0, '0, "R7 load priority");
        step(SPC, SPC, 0, '0, 0, 0, 0, 0, 0, 0, '0, "R3 pc not on A");
        step(7, 15, 5, '0, 0, 0, 0, 0, 0, 0, '0, "R7 shadow");

        // R8 memory read beats bus C load; bus C load alone
        step(1, 15, 5, '0, 0, 0, 1, 0, 1, 1, 16'hBEEF, "R8 priority");
        step(15, 15, 7, '0, 0, 0, 0, 0, 0, 1, '0, "R9 show");
        step(2, 15, 5, '0, 0, 0, 1, 0, 0, 0, '0, "R8 bus load");
        step(SMDR, SMDR, 0, '0, 0, 0, 0, 0, 0, 1, '0, "R9 show");
        step(15, 15, 7, '0, 0, 0, 0, 0, 0, 0, '0, "R9 hidden");

        // R3 R4 unused select codes
        for (int s = N + 2; s < 16; s++) alu(s, s, 3, '0, 0, "R3 R4 unused select");

        @(negedge clk);
        #4;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule